// File: doc/BRIEF.md
# MPU-401 Host Port Emulation

This block sits between an ISA-style host I/O bus and an internal MIDI engine and presents the two-register programming model of an MPU-401 adapter. The host side is asynchronous: a 10-bit I/O address, an active-low address-enable, active-low read and write strobes, an active-low chip select and an 8-bit data bus split into input, output and output-enable. A two-bit strap picks one of four base addresses. The data register sits at base+0. Base+1 takes commands on write and returns status on read.

Host strobes are brought into the internal clock with two-flop synchronisers, and the address, data and decode result are snapshotted while the raw strobe is low. A transfer is committed on the detected rising edge of the strobe. Host-to-device bytes go out through a one-entry slot with a valid/ready handshake and a flag that marks command bytes. Device-to-host bytes arrive through a one-entry slot that the host drains by reading the data register. The block also drives a data-buffer enable toward an external transceiver and an active-high interrupt. Its reset input polarity is chosen by a strap.

Top module: `mpu_host_port`

## Requirements
- R1: While reset is active and on the first cycle after it, h2d_valid is 0, d2h_ready is 1 and host_irq is 0, and a status read then returns 0xBF.
- R2: base_sel selects the decode base: 00 gives 0x320, 01 gives 0x330, 10 gives 0x340 and 11 gives 0x350. Bits ha[9:1] must equal the base, and ha[0] picks the register (0 = data, 1 = command/status). An access at any other address has no effect and leaves bufen_n high.
- R3: While aen_n is 1 every host access is ignored. While cs_n is 0 and aen_n is 0 the port is selected whatever ha[9:1] holds, and ha[0] still picks the register.
- R4: bufen_n is 0 exactly while the port is selected and ior_n or iow_n is 0. hd_oe is 1 only while the port is selected and ior_n is 0.
- R5: A host write to base+0 presents the byte on h2d_data with h2d_is_cmd = 0. A host write to base+1 presents it with h2d_is_cmd = 1. Both appear three clock edges after iow_n rises, and h2d_valid stays high until h2d_ready is seen high.
- R6: A status read returns bit 7 = 0 when a device byte waits and 1 otherwise, bit 6 = 1 while the outgoing slot holds a byte and 0 otherwise, and bits 5..0 = 1. A status read changes no state.
- R7: When d2h_valid and d2h_ready are both 1 at a clock edge, the byte is stored and d2h_ready drops. Offers made while d2h_ready is low are not taken. A host read of base+0 returns the stored byte, and the slot frees once ior_n has risen.
- R8: A host write committed while the outgoing slot is full is dropped. If the internal side takes the old byte in the same cycle as the commit, the new byte is accepted.
- R9: host_irq is 1 whenever a device byte waits. With txirq_en = 1 it is also raised when the outgoing slot drains to empty, and held until the next host write commit. With txirq_en = 0 a drain never raises it.
- R10: Reset is active while rst_in equals rst_pol: rst_pol = 1 means active high and rst_pol = 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_in | input | 1 | Raw reset pin, polarity set by rst_pol |
| rst_pol | input | 1 | Reset polarity strap (1 = active high) |
| base_sel | input | 2 | Base address strap |
| txirq_en | input | 1 | Enables the transmit-ready interrupt |
| ha | input | 10 | Host I/O address |
| aen_n | input | 1 | Host address enable, active low |
| cs_n | input | 1 | Qualified chip select, active low; tie high if unused |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| hd_i | input | 8 | Host data bus, inbound |
| hd_o | output | 8 | Host data bus, outbound |
| hd_oe | output | 1 | Host data bus drive enable |
| bufen_n | output | 1 | External data buffer enable, active low |
| host_irq | output | 1 | Host interrupt, active high |
| h2d_valid | output | 1 | Host byte available to the internal side |
| h2d_data | output | 8 | Host byte |
| h2d_is_cmd | output | 1 | Host byte came from a command write |
| h2d_ready | input | 1 | Internal side takes the host byte |
| d2h_valid | input | 1 | Internal side offers a byte to the host |
| d2h_data | input | 8 | Byte for the host |
| d2h_ready | output | 1 | Device-to-host slot is free |

## Verification
Two functions can land in the same cycle: a committed host write, and the internal side draining the outgoing slot that the write needs. The bench fills the slot, drops a second write to confirm the full-slot rule, then counts edges from the rising write strobe. It raises h2d_ready only across the third edge, where the commit falls. The check passes only if the slot comes out still valid and holding the newer byte, which shows that the drain freed room for the same-cycle commit and did not cause a loss.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;

    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 2;
    localparam int BASE_LOW  = 16'h0320;
    localparam int BASE_STEP = 16'h0010;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;

    // captured view of a host write while the raw strobe is low
    typedef struct packed {
        logic              hit;
        reg_sel_e          rsel;
        logic [DATA_W-1:0] data;
    } wr_snap_t;

    // captured view of a host read while the raw strobe is low
    typedef struct packed {
        logic     hit;
        reg_sel_e rsel;
    } rd_snap_t;

    // outgoing byte plus its command marker
    typedef struct packed {
        logic              is_cmd;
        logic [DATA_W-1:0] data;
    } h2d_word_t;

    function automatic logic [15:0] base_of(input logic [SEL_W-1:0] bs);
        return 16'(BASE_LOW + BASE_STEP * int'(bs));
    endfunction

    // ready bits are active low for receive, busy-high for transmit
    function automatic logic [DATA_W-1:0] status_byte(input logic rx_full,
                                                      input logic tx_full);
        return {~rx_full, tx_full, {(DATA_W-2){1'b1}}};
    endfunction

endpackage

// File: rtl/mpu_strobe_sync.sv
module mpu_strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '1;
                    else     chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
    import mpu_port_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0]    ha,
    input  logic             aen_n,
    input  logic             cs_n,
    input  logic [SEL_W-1:0] base_sel,
    output logic             hit,
    output reg_sel_e         rsel
);
    logic [AW-1:0] base;
    logic          addr_hit;

    assign base     = AW'(base_of(base_sel));
    assign addr_hit = ({ha[AW-1:1], 1'b0} == base);
    assign hit      = ~aen_n & (~cs_n | addr_hit);
    assign rsel     = reg_sel_e'(ha[0]);

endmodule

// File: rtl/mpu_byte_slot.sv
module mpu_byte_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         drain,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (load) begin
            full <= 1'b1;
            data <= load_data;
        end else if (drain) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/mpu_host_port.sv
module mpu_host_port
    import mpu_port_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_in,
    input  logic             rst_pol,
    input  logic [SEL_W-1:0] base_sel,
    input  logic             txirq_en,
    input  logic [AW-1:0]    ha,
    input  logic             aen_n,
    input  logic             cs_n,
    input  logic             ior_n,
    input  logic             iow_n,
    input  logic [DW-1:0]    hd_i,
    output logic [DW-1:0]    hd_o,
    output logic             hd_oe,
    output logic             bufen_n,
    output logic             host_irq,
    output logic             h2d_valid,
    output logic [DW-1:0]    h2d_data,
    output logic             h2d_is_cmd,
    input  logic             h2d_ready,
    input  logic             d2h_valid,
    input  logic [DW-1:0]    d2h_data,
    output logic             d2h_ready
);
    localparam int TXW = DW + 1;

    logic      rst_act;
    logic      dec_hit;
    reg_sel_e  dec_rsel;
    logic [1:0] strobe_rise;
    logic      rd_rise, wr_rise;
    wr_snap_t  wr_snap;
    rd_snap_t  rd_snap;
    logic      wr_commit, rd_commit;
    logic      tx_full, tx_take, tx_accept;
    h2d_word_t tx_word, tx_in;
    logic      rx_full, rx_load, rx_drain;
    logic [DW-1:0] rx_data;
    logic      tx_irq_flag;

    // reset is active when the pin matches the strap
    assign rst_act = ~(rst_in ^ rst_pol);

    mpu_addr_decode #(.AW(AW)) i_decode (
        .ha       (ha),
        .aen_n    (aen_n),
        .cs_n     (cs_n),
        .base_sel (base_sel),
        .hit      (dec_hit),
        .rsel     (dec_rsel)
    );

    mpu_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst_act),
        .async_in ({ior_n, iow_n}),
        .rise     (strobe_rise)
    );
    assign wr_rise = strobe_rise[0];
    assign rd_rise = strobe_rise[1];

    // snapshot the bus while each raw strobe is low; commit on its rise
    always_ff @(posedge clk) begin
        if (rst_act) begin
            wr_snap <= '0;
            rd_snap <= '0;
        end else begin
            if (!iow_n) wr_snap <= '{hit: dec_hit, rsel: dec_rsel, data: hd_i};
            if (!ior_n) rd_snap <= '{hit: dec_hit, rsel: dec_rsel};
        end
    end

    assign wr_commit = wr_rise & wr_snap.hit;
    assign rd_commit = rd_rise & rd_snap.hit;

    // host to device slot
    assign tx_take   = tx_full & h2d_ready;
    assign tx_accept = wr_commit & (~tx_full | tx_take);
    assign tx_in     = '{is_cmd: (wr_snap.rsel == REG_CTRL), data: wr_snap.data};

    mpu_byte_slot #(.W(TXW)) i_tx_slot (
        .clk       (clk),
        .rst       (rst_act),
        .load      (tx_accept),
        .load_data (tx_in),
        .drain     (tx_take),
        .full      (tx_full),
        .data      (tx_word)
    );

    assign h2d_valid  = tx_full;
    assign h2d_data   = tx_word.data;
    assign h2d_is_cmd = tx_word.is_cmd;

    // device to host slot
    assign rx_load  = d2h_valid & ~rx_full;
    assign rx_drain = rd_commit & (rd_snap.rsel == REG_DATA) & rx_full;

    mpu_byte_slot #(.W(DW)) i_rx_slot (
        .clk       (clk),
        .rst       (rst_act),
        .load      (rx_load),
        .load_data (d2h_data),
        .drain     (rx_drain),
        .full      (rx_full),
        .data      (rx_data)
    );

    assign d2h_ready = ~rx_full;

    // transmit-ready interrupt: set on drain to empty, cleared by a host write
    always_ff @(posedge clk) begin
        if (rst_act)                       tx_irq_flag <= 1'b0;
        else if (wr_commit || !txirq_en)   tx_irq_flag <= 1'b0;
        else if (tx_take && !tx_accept)    tx_irq_flag <= 1'b1;
    end

    assign host_irq = rx_full | tx_irq_flag;

    // host facing outputs are purely combinational from the pins
    assign hd_oe   = dec_hit & ~ior_n;
    assign bufen_n = ~(dec_hit & (~ior_n | ~iow_n));
    assign hd_o    = (dec_rsel == REG_CTRL) ? status_byte(rx_full, tx_full) : rx_data;

endmodule

// File: rtl/mpu_host_port_checker.sv
module mpu_host_port_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          h2d_valid,
    input logic          h2d_ready,
    input logic [DW-1:0] h2d_data,
    input logic          h2d_is_cmd,
    input logic          d2h_valid,
    input logic          d2h_ready,
    input logic          host_irq,
    input logic          hd_oe,
    input logic          bufen_n,
    input logic          ha_a0,
    input logic [5:0]    stat_low
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!h2d_valid && d2h_ready && !host_irq));

    assert_bufen_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> !bufen_n);

    assert_status_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (hd_oe && ha_a0) |-> (stat_low == 6'h3f));

    assert_rx_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (d2h_valid && d2h_ready) |=> !d2h_ready);

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (h2d_valid && !h2d_ready) |=> (h2d_valid && $stable(h2d_data) && $stable(h2d_is_cmd)));

    assert_irq_rx_R9: assert property (@(posedge clk) disable iff (rst)
        !d2h_ready |-> host_irq);

endmodule

bind mpu_host_port mpu_host_port_checker #(.DW(DW)) i_checker (
    .clk        (clk),
    .rst        (rst_act),
    .h2d_valid  (h2d_valid),
    .h2d_ready  (h2d_ready),
    .h2d_data   (h2d_data),
    .h2d_is_cmd (h2d_is_cmd),
    .d2h_valid  (d2h_valid),
    .d2h_ready  (d2h_ready),
    .host_irq   (host_irq),
    .hd_oe      (hd_oe),
    .bufen_n    (bufen_n),
    .ha_a0      (ha[0]),
    .stat_low   (hd_o[5:0])
);

// File: tb/test_mpu_host_port.sv
module test_mpu_host_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_in, rst_pol;
    logic [1:0] base_sel;
    logic       txirq_en;
    logic [9:0] ha;
    logic       aen_n, cs_n, ior_n, iow_n;
    logic [7:0] hd_i, hd_o;
    logic       hd_oe, bufen_n, host_irq;
    logic       h2d_valid, h2d_is_cmd, h2d_ready;
    logic [7:0] h2d_data;
    logic       d2h_valid, d2h_ready;
    logic [7:0] d2h_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_host_port i_mpu_host_port (
        .clk(clk), .rst_in(rst_in), .rst_pol(rst_pol), .base_sel(base_sel),
        .txirq_en(txirq_en), .ha(ha), .aen_n(aen_n), .cs_n(cs_n),
        .ior_n(ior_n), .iow_n(iow_n), .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe),
        .bufen_n(bufen_n), .host_irq(host_irq), .h2d_valid(h2d_valid),
        .h2d_data(h2d_data), .h2d_is_cmd(h2d_is_cmd), .h2d_ready(h2d_ready),
        .d2h_valid(d2h_valid), .d2h_data(d2h_data), .d2h_ready(d2h_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // write strobe low for two cycles, then released; bus dropped at release
    task automatic host_write(input logic [9:0] addr, input logic [7:0] data,
                              output logic buf_mid);
        @(negedge clk);
        ha = addr; hd_i = data; aen_n = 1'b0; iow_n = 1'b0;
        repeat (2) @(negedge clk);
        buf_mid = bufen_n;
        iow_n = 1'b1; aen_n = 1'b1; ha = '0; hd_i = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic [9:0] addr, output logic [7:0] data,
                             output logic oe, output logic buf_mid);
        @(negedge clk);
        ha = addr; aen_n = 1'b0; ior_n = 1'b0;
        repeat (2) @(negedge clk);
        data = hd_o; oe = hd_oe; buf_mid = bufen_n;
        ior_n = 1'b1; aen_n = 1'b1; ha = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic push_d2h(input logic [7:0] data);
        @(negedge clk);
        d2h_valid = 1'b1; d2h_data = data;
        @(negedge clk);
        d2h_valid = 1'b0;
    endtask

    task automatic take_h2d;
        @(negedge clk);
        h2d_ready = 1'b1;
        @(negedge clk);
        h2d_ready = 1'b0;
    endtask

    task automatic t_reset_r1;
        logic [7:0] d; logic oe, b;
        chk("R1 h2d_valid", h2d_valid, 0);
        chk("R1 d2h_ready", d2h_ready, 1);
        chk("R1 host_irq", host_irq, 0);
        chk("R1 bufen_n idle", bufen_n, 1);
        host_read(10'h321, d, oe, b);
        chk("R1 status after reset", d, 8'hBF);
    endtask

    task automatic t_base_r2_r5;
        logic b;
        for (int s = 0; s < 4; s++) begin
            base_sel = 2'(s);
            host_write(10'h320 + 10'(16 * s), 8'h40 + 8'(s), b);
            chk("R2 bufen_n low on hit", b, 0);
            chk("R2 R5 valid after data write", h2d_valid, 1);
            chk("R5 data byte", h2d_data, 8'h40 + 8'(s));
            chk("R5 data flag", h2d_is_cmd, 0);
            take_h2d();
            chk("R5 slot freed", h2d_valid, 0);
        end
        base_sel = 2'b01;
        host_write(10'h360, 8'h77, b);
        chk("R2 off-base bufen_n", b, 1);
        chk("R2 off-base ignored", h2d_valid, 0);
        host_write(10'h331, 8'hFF, b);
        chk("R5 command valid", h2d_valid, 1);
        chk("R5 command byte", h2d_data, 8'hFF);
        chk("R5 command flag", h2d_is_cmd, 1);
        take_h2d();
    endtask

    task automatic t_aen_cs_r3;
        logic b;
        @(negedge clk);
        ha = 10'h330; hd_i = 8'h12; aen_n = 1'b1; iow_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 aen high bufen_n", bufen_n, 1);
        iow_n = 1'b1; ha = '0;
        repeat (4) @(negedge clk);
        chk("R3 aen high ignored", h2d_valid, 0);
        cs_n = 1'b0;
        host_write(10'h000, 8'h34, b);
        chk("R3 cs data valid", h2d_valid, 1);
        chk("R3 cs data byte", h2d_data, 8'h34);
        chk("R3 cs data flag", h2d_is_cmd, 0);
        take_h2d();
        host_write(10'h001, 8'h3F, b);
        chk("R3 cs command flag", h2d_is_cmd, 1);
        take_h2d();
        cs_n = 1'b1;
    endtask

    task automatic t_bufen_r4;
        logic [7:0] d; logic oe, b;
        host_read(10'h331, d, oe, b);
        chk("R4 read bufen_n", b, 0);
        chk("R4 read hd_oe", oe, 1);
        @(negedge clk);
        ha = 10'h330; aen_n = 1'b0; iow_n = 1'b0;
        @(negedge clk);
        chk("R4 write hd_oe", hd_oe, 0);
        chk("R4 write bufen_n", bufen_n, 0);
        iow_n = 1'b1; aen_n = 1'b1;
        repeat (4) @(negedge clk);
        take_h2d();
    endtask

    task automatic t_status_rx_r6_r7;
        logic [7:0] d; logic oe, b;
        push_d2h(8'h5A);
        chk("R7 slot taken", d2h_ready, 0);
        @(negedge clk);
        d2h_valid = 1'b1; d2h_data = 8'h11;
        @(negedge clk);
        d2h_valid = 1'b0;
        host_read(10'h331, d, oe, b);
        chk("R6 status data waiting", d, 8'h3F);
        host_read(10'h331, d, oe, b);
        chk("R6 status read no side effect", d, 8'h3F);
        chk("R6 rx still full", d2h_ready, 0);
        chk("R9 irq with rx data", host_irq, 1);
        host_read(10'h330, d, oe, b);
        chk("R7 read byte, offer while full ignored", d, 8'h5A);
        chk("R7 slot freed", d2h_ready, 1);
        chk("R9 irq cleared", host_irq, 0);
    endtask

    task automatic t_full_drop_r8;
        logic [7:0] d; logic oe, b;
        host_write(10'h330, 8'h21, b);
        host_read(10'h331, d, oe, b);
        chk("R6 status busy", d, 8'hFF);
        host_write(10'h330, 8'h22, b);
        chk("R8 dropped write keeps old", h2d_data, 8'h21);
        // coincidence: drain on the same edge as the commit of 0x23
        @(negedge clk);
        ha = 10'h330; hd_i = 8'h23; aen_n = 1'b0; iow_n = 1'b0;
        repeat (2) @(negedge clk);
        iow_n = 1'b1; aen_n = 1'b1; ha = '0; hd_i = '0;
        @(negedge clk);
        @(negedge clk);
        h2d_ready = 1'b1;
        @(negedge clk);
        h2d_ready = 1'b0;
        chk("R8 same-cycle drain valid", h2d_valid, 1);
        chk("R8 same-cycle drain byte", h2d_data, 8'h23);
        take_h2d();
        chk("R8 drained", h2d_valid, 0);
    endtask

    task automatic t_irq_r9;
        logic b;
        txirq_en = 1'b0;
        host_write(10'h330, 8'h01, b);
        take_h2d();
        chk("R9 no tx irq when disabled", host_irq, 0);
        txirq_en = 1'b1;
        host_write(10'h330, 8'h02, b);
        chk("R9 no irq while busy", host_irq, 0);
        take_h2d();
        chk("R9 tx irq on drain", host_irq, 1);
        host_write(10'h331, 8'h03, b);
        chk("R9 tx irq cleared by write", host_irq, 0);
        take_h2d();
        txirq_en = 1'b0;
        @(negedge clk);
        chk("R9 tx irq off when disabled", host_irq, 0);
    endtask

    task automatic t_polarity_r10;
        @(negedge clk);
        rst_pol = 1'b0; rst_in = 1'b1;
        push_d2h(8'h66);
        @(negedge clk);
        chk("R10 high pin not reset when active low", d2h_ready, 0);
        rst_in = 1'b0;
        @(negedge clk);
        rst_in = 1'b1;
        @(negedge clk);
        chk("R10 low pin resets when active low", d2h_ready, 1);
        chk("R10 irq after reset", host_irq, 0);
        rst_pol = 1'b1; rst_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_in = 1'b1; rst_pol = 1'b1; base_sel = 2'b00; txirq_en = 1'b0;
        ha = '0; aen_n = 1'b1; cs_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
        hd_i = '0; h2d_ready = 1'b0; d2h_valid = 1'b0; d2h_data = '0;
        repeat (3) @(negedge clk);
        rst_in = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_base_r2_r5();
        base_sel = 2'b01;
        t_aen_cs_r3();
        t_bufen_r4();
        t_status_rx_r6_r7();
        t_full_drop_r8();
        t_irq_r9();
        t_polarity_r10();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule